// File: doc/BRIEF.md
# SPI Host Register and FIFO Front End

This block is the software-facing side of an SPI host controller. A simple 32-bit register bus reaches a small set of control and status registers and two byte-wide data windows: bytes written to the transmit window are queued for the serial engine, and reads of the receive window return bytes the serial engine has captured. Both queues hold 128 bytes. A single status word reports how full each queue is, and each queue can be emptied independently by writing a self-clearing flush bit.

The serial engine and the bit-clock generator live outside this block. They take bytes from the transmit queue through a pop strobe, deliver received bytes through a push strobe, and report the end of a transfer with a one-cycle event strobe. The block keeps an interrupt status register (receive overflow and transfer done), an interrupt enable register, and drives one interrupt line that is high while any enabled status bit is set. A global control register carries the bus enable, host mode and transmit pause levels for the engine, plus a soft reset bit that pulses for one cycle.

Bus accesses complete in the cycle they are presented: read data is valid combinationally while `bus_req` is high with `bus_we` low, and the pop or register update takes effect at the closing clock edge.

Top module: `spi_host_csr_fifo`

## Requirements
- R1: After reset every readable register (0x04, 0x10, 0x14, 0x18, 0x1C) reads zero, `irq` and all `ctl_*` outputs are low and `eng_tx_empty` is high.
- R2: A bus write to offset 0x200 queues `bus_wdata[7:0]` in the transmit FIFO; `eng_tx_pop` removes bytes in write order and `eng_tx_data` shows the oldest byte; writes to a full (128-byte) transmit FIFO are dropped; a pop of an empty FIFO has no effect, `eng_tx_data` is zero while empty, and `eng_tx_empty` is high exactly when the transmit level is zero.
- R3: A bus read of offset 0x300 returns the oldest received byte in bits [7:0] (upper bits zero) and removes it; a read while the receive FIFO is empty returns zero and leaves the level at zero.
- R4: Offset 0x1C reads the receive level in bits [7:0] and the transmit level in bits [23:16], each from 0 up to 128, all other bits zero; writes to it are ignored.
- R5: At offset 0x18, writing bit 15 empties the receive FIFO and writing bit 31 empties the transmit FIFO at the closing edge of the write, each leaving the other FIFO untouched; a flush wins over an engine push in the same cycle; the register reads zero.
- R6: An engine push into a full receive FIFO with no bus pop in the same cycle drops the byte and sets status bit 8; if a bus pop of the receive window happens in the same cycle, the byte is accepted and the level stays at 128.
- R7: A pulse on `evt_xfer_done` sets status bit 12 at offset 0x14.
- R8: Writing a one to status bit 8 or 12 clears it, writing zero leaves it; an event that sets a bit in the same cycle as its clearing write leaves the bit set.
- R9: The enable register at 0x10 stores bits 8 and 12 only (other bits read zero); `irq` is high from the cycle after the registers change whenever a status bit and its enable bit are both one.
- R10: Offset 0x04 stores bus enable (bit 0), host mode (bit 1) and transmit pause (bit 7), which drive `ctl_bus_en`, `ctl_host_mode` and `ctl_tx_pause`; other bits read zero.
- R11: Writing bit 31 of offset 0x04 raises `ctl_soft_rst` for exactly one cycle after the write, empties both FIFOs at the closing edge of the write, and reads back as zero.
- R12: Reads of unmapped offsets and of the transmit window return zero and change nothing; writes to unmapped offsets and the receive window change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte, zero when empty |
| eng_tx_empty | output | 1 | Transmit FIFO is empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| evt_xfer_done | input | 1 | One-cycle transfer-complete event |
| ctl_bus_en | output | 1 | Bus enable level |
| ctl_host_mode | output | 1 | Host mode level |
| ctl_tx_pause | output | 1 | Transmit pause level |
| ctl_soft_rst | output | 1 | One-cycle soft reset pulse |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions matter here. An engine push into a full receive FIFO can meet a bus read of the receive window in the same cycle, and a transfer-done event can meet a write-one-to-clear of its own status bit. The bench first fills the receive FIFO to 128, then drives the push and the window read in one cycle and expects the oldest byte back, a level still at 128 and no overflow flag; for the second it pulses the event during the clearing write and expects bit 12 to read back set. Both are judged only through register reads and the interrupt line.

// File: rtl/spih_pkg.sv
package spih_pkg;

    localparam int BUS_W = 32;

    // register offsets (byte addresses)
    localparam int OFS_GCTL  = 'h004;
    localparam int OFS_IEN   = 'h010;
    localparam int OFS_ISTS  = 'h014;
    localparam int OFS_FCTL  = 'h018;
    localparam int OFS_FSTS  = 'h01C;
    localparam int OFS_TXWIN = 'h200;
    localparam int OFS_RXWIN = 'h300;

    // global control bits
    localparam int GC_BUS_EN   = 0;
    localparam int GC_HOST     = 1;
    localparam int GC_TX_PAUSE = 7;
    localparam int GC_SOFT_RST = 31;

    // FIFO control bits
    localparam int FC_RX_FLUSH = 15;
    localparam int FC_TX_FLUSH = 31;

    // FIFO status field positions
    localparam int FS_RX_LSB = 0;
    localparam int FS_TX_LSB = 16;

    // interrupt bits
    localparam int IRQ_OVF  = 8;
    localparam int IRQ_DONE = 12;
    localparam logic [BUS_W-1:0] IRQ_MASK = (BUS_W'(1) << IRQ_OVF) | (BUS_W'(1) << IRQ_DONE);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GCTL,
        SEL_IEN,
        SEL_ISTS,
        SEL_FCTL,
        SEL_FSTS,
        SEL_TXWIN,
        SEL_RXWIN
    } reg_sel_e;

    typedef struct packed {
        logic bus_en;
        logic host_mode;
        logic tx_pause;
        logic soft_rst;
    } gctl_t;

endpackage

// File: rtl/spih_byte_fifo.sv
module spih_byte_fifo #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush,
    input  logic                             push,
    input  logic [WIDTH-1:0]                 push_data,
    input  logic                             pop,
    output logic [WIDTH-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]       level
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t         st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             do_push, do_pop, wr_mem;

    always_comb begin
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CNT_FULL) || do_pop);
        wr_mem  = do_push && !flush;
        st_d    = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = (st_q.wr == PTR_LAST) ? '0 : st_q.wr + 1'b1;
            if (do_pop)  st_d.rd = (st_q.rd == PTR_LAST) ? '0 : st_q.rd + 1'b1;
            st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_mem) mem_q[st_q.wr] <= push_data;
    end

    assign head  = (st_q.cnt == '0) ? '0 : mem_q[st_q.rd];
    assign level = st_q.cnt;

endmodule

// File: rtl/spih_irq_ctrl.sv
module spih_irq_ctrl
    import spih_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             sts_wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             ev_ovf,
    input  logic             ev_done,
    output logic [BUS_W-1:0] en_word,
    output logic [BUS_W-1:0] sts_word,
    output logic             irq
);

    typedef struct packed {
        logic [BUS_W-1:0] en;
        logic [BUS_W-1:0] sts;
    } irq_st_t;

    irq_st_t          st_d, st_q;
    logic [BUS_W-1:0] set_vec, clr_vec;

    always_comb begin
        set_vec = '0;
        set_vec[IRQ_OVF]  = ev_ovf;
        set_vec[IRQ_DONE] = ev_done;
        clr_vec = sts_wr ? wdata : '0;
        st_d    = st_q;
        if (en_wr) st_d.en = wdata & IRQ_MASK;
        // a new event wins over a clearing write in the same cycle
        st_d.sts = ((st_q.sts & ~clr_vec) | set_vec) & IRQ_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_word  = st_q.en;
    assign sts_word = st_q.sts;
    assign irq      = |(st_q.sts & st_q.en);

endmodule

// File: rtl/spi_host_csr_fifo.sv
module spi_host_csr_fifo
    import spih_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              eng_tx_pop,
    output logic [7:0]        eng_tx_data,
    output logic              eng_tx_empty,
    input  logic              eng_rx_push,
    input  logic [7:0]        eng_rx_data,
    input  logic              evt_xfer_done,
    output logic              ctl_bus_en,
    output logic              ctl_host_mode,
    output logic              ctl_tx_pause,
    output logic              ctl_soft_rst,
    output logic              irq
);

    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    reg_sel_e         sel;
    gctl_t            gctl_d, gctl_q;
    logic             wr_en, rd_en;
    logic             tx_push, rx_pop, rx_flush, tx_flush, soft_wr, rx_ovf;
    logic             en_wr, sts_wr;
    logic [7:0]       rx_head;
    logic [CNT_W-1:0] rx_level, tx_level;
    logic [BUS_W-1:0] en_word, sts_word;

    // decode and next-state of the global control register
    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFS_GCTL):  sel = SEL_GCTL;
            ADDR_W'(OFS_IEN):   sel = SEL_IEN;
            ADDR_W'(OFS_ISTS):  sel = SEL_ISTS;
            ADDR_W'(OFS_FCTL):  sel = SEL_FCTL;
            ADDR_W'(OFS_FSTS):  sel = SEL_FSTS;
            ADDR_W'(OFS_TXWIN): sel = SEL_TXWIN;
            ADDR_W'(OFS_RXWIN): sel = SEL_RXWIN;
            default:            sel = SEL_NONE;
        endcase

        wr_en    = bus_req && bus_we;
        rd_en    = bus_req && !bus_we;
        tx_push  = wr_en && (sel == SEL_TXWIN);
        rx_pop   = rd_en && (sel == SEL_RXWIN);
        en_wr    = wr_en && (sel == SEL_IEN);
        sts_wr   = wr_en && (sel == SEL_ISTS);
        soft_wr  = wr_en && (sel == SEL_GCTL) && bus_wdata[GC_SOFT_RST];
        rx_flush = soft_wr || (wr_en && (sel == SEL_FCTL) && bus_wdata[FC_RX_FLUSH]);
        tx_flush = soft_wr || (wr_en && (sel == SEL_FCTL) && bus_wdata[FC_TX_FLUSH]);
        // full receive FIFO: a byte is lost unless the bus frees a slot now
        rx_ovf   = eng_rx_push && (rx_level == CNT_FULL) && !rx_pop;

        gctl_d          = gctl_q;
        gctl_d.soft_rst = 1'b0;
        if (wr_en && (sel == SEL_GCTL)) begin
            gctl_d.bus_en    = bus_wdata[GC_BUS_EN];
            gctl_d.host_mode = bus_wdata[GC_HOST];
            gctl_d.tx_pause  = bus_wdata[GC_TX_PAUSE];
            gctl_d.soft_rst  = bus_wdata[GC_SOFT_RST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gctl_q <= '0;
        else        gctl_q <= gctl_d;
    end

    spih_byte_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (8)
    ) tx_fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (tx_push),
        .push_data (bus_wdata[7:0]),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .level     (tx_level)
    );

    spih_byte_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (8)
    ) rx_fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .level     (rx_level)
    );

    spih_irq_ctrl irq_ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .sts_wr   (sts_wr),
        .wdata    (bus_wdata),
        .ev_ovf   (rx_ovf),
        .ev_done  (evt_xfer_done),
        .en_word  (en_word),
        .sts_word (sts_word),
        .irq      (irq)
    );

    // read-data mux
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_GCTL: begin
                    bus_rdata[GC_BUS_EN]   = gctl_q.bus_en;
                    bus_rdata[GC_HOST]     = gctl_q.host_mode;
                    bus_rdata[GC_TX_PAUSE] = gctl_q.tx_pause;
                end
                SEL_IEN:   bus_rdata = en_word;
                SEL_ISTS:  bus_rdata = sts_word;
                SEL_FSTS:  bus_rdata = (BUS_W'(rx_level) << FS_RX_LSB)
                                     | (BUS_W'(tx_level) << FS_TX_LSB);
                SEL_RXWIN: bus_rdata = BUS_W'(rx_head);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign eng_tx_empty  = (tx_level == '0);
    assign ctl_bus_en    = gctl_q.bus_en;
    assign ctl_host_mode = gctl_q.host_mode;
    assign ctl_tx_pause  = gctl_q.tx_pause;
    assign ctl_soft_rst  = gctl_q.soft_rst;

endmodule

// File: rtl/spih_chk.sv
module spih_chk #(
    parameter int DEPTH = 128
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       eng_rx_push,
    input logic                       eng_tx_empty,
    input logic                       evt_xfer_done,
    input logic                       ctl_soft_rst,
    input logic                       irq,
    input logic                       rx_pop,
    input logic                       rx_flush,
    input logic                       tx_flush,
    input logic [$clog2(DEPTH+1)-1:0] rx_level,
    input logic [$clog2(DEPTH+1)-1:0] tx_level,
    input logic                       sts_ovf,
    input logic                       sts_done,
    input logic                       ien_ovf,
    input logic                       ien_done
);

    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    AST_LEVEL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= CNT_FULL) && (tx_level <= CNT_FULL)); // R4

    AST_TX_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        eng_tx_empty == (tx_level == '0)); // R2

    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (rx_level == '0)); // R5

    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> (tx_level == '0)); // R5

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && (rx_level == CNT_FULL) && !rx_pop) |=> sts_ovf); // R6

    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        evt_xfer_done |=> sts_done); // R7

    AST_SRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_soft_rst |=> !ctl_soft_rst); // R11

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien_ovf && !ien_done) |-> !irq); // R9

endmodule

bind spi_host_csr_fifo spih_chk #(.DEPTH(DEPTH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .eng_rx_push   (eng_rx_push),
    .eng_tx_empty  (eng_tx_empty),
    .evt_xfer_done (evt_xfer_done),
    .ctl_soft_rst  (ctl_soft_rst),
    .irq           (irq),
    .rx_pop        (rx_pop),
    .rx_flush      (rx_flush),
    .tx_flush      (tx_flush),
    .rx_level      (rx_level),
    .tx_level      (tx_level),
    .sts_ovf       (sts_word[spih_pkg::IRQ_OVF]),
    .sts_done      (sts_word[spih_pkg::IRQ_DONE]),
    .ien_ovf       (en_word[spih_pkg::IRQ_OVF]),
    .ien_done      (en_word[spih_pkg::IRQ_DONE])
);

// File: tb/spi_host_csr_fifo_tb_top.sv
`timescale 1ns/1ps
module spi_host_csr_fifo_tb_top;

    localparam int DEPTH = 128;
    localparam logic [11:0] A_GCTL = 12'h004, A_IEN = 12'h010, A_ISTS = 12'h014,
                            A_FCTL = 12'h018, A_FSTS = 12'h01C, A_TXW = 12'h200,
                            A_RXW = 12'h300, A_HOLE = 12'h008;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0, evt_xfer_done = 1'b0;
    logic [7:0]  eng_rx_data = '0, eng_tx_data;
    logic        eng_tx_empty, ctl_bus_en, ctl_host_mode, ctl_tx_pause, ctl_soft_rst, irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] rd;
    logic [7:0]  b;

    always #4 clk = ~clk;

    spi_host_csr_fifo #(.DEPTH(DEPTH), .ADDR_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_empty(eng_tx_empty),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .evt_xfer_done(evt_xfer_done),
        .ctl_bus_en(ctl_bus_en), .ctl_host_mode(ctl_host_mode), .ctl_tx_pause(ctl_tx_pause),
        .ctl_soft_rst(ctl_soft_rst), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk); #1;
        bus_req = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] v);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = v;
        @(posedge clk); #1;
        eng_rx_push = 1'b0;
    endtask

    task automatic tx_pop(output logic [7:0] v);
        @(negedge clk);
        eng_tx_pop = 1'b1;
        #2 v = eng_tx_data;
        @(posedge clk); #1;
        eng_tx_pop = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        evt_xfer_done = 1'b1;
        @(posedge clk); #1;
        evt_xfer_done = 1'b0;
    endtask

    function automatic logic [31:0] imap(input int v);
        return ((v & 1) != 0 ? 32'h0000_0100 : 32'h0) | ((v & 2) != 0 ? 32'h0000_1000 : 32'h0);
    endfunction

    function automatic logic [31:0] lvl(input int rx, input int tx);
        return (32'(rx) & 32'hFF) | ((32'(tx) & 32'hFF) << 16);
    endfunction

    task automatic set_status(input int s);
        bus_wr(A_ISTS, 32'hFFFF_FFFF);
        if ((s & 1) != 0) rx_push(8'h11);   // receive FIFO is kept full here
        if ((s & 2) != 0) done_pulse();
    endtask

    task automatic fill_rx();
        for (int k = 0; k < DEPTH; k++) rx_push(8'((k * 13 + 5) & 255));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        bus_rd(A_GCTL, rd); chk("R1 gctl", rd, 0);
        bus_rd(A_IEN, rd);  chk("R1 ien", rd, 0);
        bus_rd(A_ISTS, rd); chk("R1 ists", rd, 0);
        bus_rd(A_FCTL, rd); chk("R1 fctl", rd, 0);
        bus_rd(A_FSTS, rd); chk("R1 fsts", rd, 0);
        chk("R1 outputs", {27'b0, irq, ctl_bus_en, ctl_host_mode, ctl_tx_pause, ctl_soft_rst}, 0);
        chk("R1 tx_empty", 32'(eng_tx_empty), 1);

        // R2 R4: transmit fill sweep past full
        for (int i = 0; i < DEPTH + 2; i++) begin
            bus_wr(A_TXW, 32'hABCD_0000 | 32'((i * 7 + 3) & 255));
            bus_rd(A_FSTS, rd);
            chk("R4 tx level", rd, lvl(0, (i + 1 < DEPTH) ? i + 1 : DEPTH));
        end
        chk("R2 tx_empty low", 32'(eng_tx_empty), 0);
        for (int j = 0; j < DEPTH; j++) begin
            tx_pop(b);
            chk("R2 tx order", 32'(b), 32'((j * 7 + 3) & 255));
            bus_rd(A_FSTS, rd);
            chk("R4 tx drain level", rd, lvl(0, DEPTH - 1 - j));
        end
        chk("R2 tx_empty high", 32'(eng_tx_empty), 1);
        tx_pop(b);
        chk("R2 empty pop data", 32'(b), 0);
        bus_rd(A_FSTS, rd); chk("R2 empty pop level", rd, 0);

        // R3 R4 R6: receive fill sweep past full
        for (int i = 0; i < DEPTH + 2; i++) begin
            rx_push(8'((i * 13 + 5) & 255));
            bus_rd(A_FSTS, rd);
            chk("R4 rx level", rd, lvl((i + 1 < DEPTH) ? i + 1 : DEPTH, 0));
            bus_rd(A_ISTS, rd);
            chk("R6 overflow flag", rd, (i >= DEPTH) ? 32'h100 : 32'h0);
        end
        for (int j = 0; j < DEPTH; j++) begin
            bus_rd(A_RXW, rd);
            chk("R3 rx order", rd, 32'((j * 13 + 5) & 255));
        end
        bus_rd(A_RXW, rd); chk("R3 empty read", rd, 0);
        bus_rd(A_FSTS, rd); chk("R3 level after empty read", rd, 0);
        bus_wr(A_ISTS, 32'h100);
        bus_rd(A_ISTS, rd); chk("R8 clear ovf", rd, 0);

        // R6: push into full receive FIFO together with a bus pop
        fill_rx();
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = 8'hEE;
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = A_RXW;
        #2 rd = bus_rdata;
        @(posedge clk); #1;
        eng_rx_push = 1'b0; bus_req = 1'b0;
        chk("R6 collide data", rd, 32'h5);
        bus_rd(A_FSTS, rd); chk("R6 collide level", rd, lvl(DEPTH, 0));
        bus_rd(A_ISTS, rd); chk("R6 collide no ovf", rd, 0);

        // R5: independent flushes
        for (int k = 0; k < 3; k++) bus_wr(A_TXW, 32'(k));
        bus_wr(A_FCTL, 32'h0000_8000);
        bus_rd(A_FSTS, rd); chk("R5 rx flush only", rd, lvl(0, 3));
        bus_rd(A_FCTL, rd); chk("R5 fctl reads zero", rd, 0);
        bus_wr(A_FCTL, 32'h8000_0000);
        bus_rd(A_FSTS, rd); chk("R5 tx flush", rd, 0);
        rx_push(8'h01); rx_push(8'h02);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = 8'h03;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = A_FCTL; bus_wdata = 32'h0000_8000;
        @(posedge clk); #1;
        eng_rx_push = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
        bus_rd(A_FSTS, rd); chk("R5 flush beats push", rd, 0);

        // R7 R8: status set / write-one-to-clear sweep
        fill_rx();
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) begin
                set_status(s);
                bus_rd(A_ISTS, rd); chk("R7 status set", rd, imap(s));
                bus_wr(A_ISTS, imap(c));
                bus_rd(A_ISTS, rd); chk("R8 w1c result", rd, imap(s & ~c));
            end
        end
        bus_wr(A_ISTS, 32'hFFFF_FFFF);
        @(negedge clk);
        evt_xfer_done = 1'b1;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = A_ISTS; bus_wdata = 32'h0000_1000;
        @(posedge clk); #1;
        evt_xfer_done = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
        bus_rd(A_ISTS, rd); chk("R8 set beats clear", rd, 32'h1000);

        // R9: enable x status sweep
        for (int e = 0; e < 4; e++) begin
            bus_wr(A_IEN, imap(e) | 32'h0F0F_00F0);
            bus_rd(A_IEN, rd); chk("R9 ien readback", rd, imap(e));
            for (int s = 0; s < 4; s++) begin
                set_status(s);
                @(negedge clk);
                chk("R9 irq", 32'(irq), ((s & e) != 0) ? 1 : 0);
            end
        end
        bus_wr(A_IEN, 32'h0);
        @(negedge clk); chk("R9 irq masked", 32'(irq), 0);

        // R10: global control sweep
        for (int g = 0; g < 8; g++) begin
            logic [31:0] v;
            v = ((g & 1) != 0 ? 32'h1 : 32'h0) | ((g & 2) != 0 ? 32'h2 : 32'h0)
              | ((g & 4) != 0 ? 32'h80 : 32'h0);
            bus_wr(A_GCTL, v | 32'h0000_7F7C);
            chk("R10 ctl outputs", {28'b0, ctl_soft_rst, ctl_tx_pause, ctl_host_mode, ctl_bus_en}, 32'(g));
            bus_rd(A_GCTL, rd); chk("R10 gctl readback", rd, v);
        end

        // R11: soft reset pulse and FIFO clearing
        for (int k = 0; k < 5; k++) bus_wr(A_TXW, 32'(k));
        bus_rd(A_FSTS, rd); chk("R11 pre levels", rd, lvl(DEPTH, 5));
        bus_wr(A_GCTL, 32'h8000_0001);
        chk("R11 pulse high", 32'(ctl_soft_rst), 1);
        @(posedge clk); #1;
        chk("R11 pulse low", 32'(ctl_soft_rst), 0);
        bus_rd(A_FSTS, rd); chk("R11 fifos emptied", rd, 0);
        bus_rd(A_GCTL, rd); chk("R11 gctl readback", rd, 32'h1);

        // R12: unmapped and window accesses
        bus_rd(A_HOLE, rd); chk("R12 hole read", rd, 0);
        bus_wr(A_HOLE, 32'hFFFF_FFFF);
        bus_wr(A_FSTS, 32'hFFFF_FFFF);
        bus_wr(A_RXW, 32'h0000_00AA);
        bus_rd(A_TXW, rd); chk("R12 txwin read", rd, 0);
        bus_rd(A_FSTS, rd); chk("R12 levels untouched", rd, 0);
        bus_rd(A_GCTL, rd); chk("R12 gctl untouched", rd, 32'h1);
        bus_rd(A_IEN, rd); chk("R12 ien untouched", rd, 0);

        summary();
    end

endmodule